// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers every reset request a chip can receive and decides how deep each reset must go. Requests fall into three levels. The power-on level rebuilds everything and captures all boot-time settings. The hard level reloads the hard reset settings word. The soft level only resets the cores. A power-on reset arrives on an asynchronous active-low input. External hard and soft resets arrive on two open-drain pins that the block both senses and pulls low. A watchdog and a bus monitor each supply an expiry pulse and an enable. A test-port command strobe asks for a soft reset.

Each accepted request runs one sequence. The block pulls the pins for that level low for a fixed number of cycles and raises the matching configuration-sample strobe as it lets go. It then waits for both sensed pin levels to read high before it releases the core reset. A deeper request restarts the sequence at its own level. A request at the same or a shallower level is dropped while a sequence is running. A status register records which sources started the latest sequences; software clears its bits by writing ones.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n_i` is low, `core_rst_o`, `hard_drv_o` and `soft_drv_o` are 1 and `stat_o` equals 6'b000001. After release, both drives stay high for HARD_CYCLES cycles. As they drop, `por_cfg_smp_o` and `hrcw_smp_o` each pulse high for exactly one cycle.
- R2: Three requests start a hard sequence when the block is idle or running a soft sequence: a low sensed hard pin, an enabled watchdog expiry, or an enabled bus monitor expiry. In a hard sequence, `hard_drv_o` and `soft_drv_o` are high together for exactly HARD_CYCLES cycles. `hrcw_smp_o` then pulses once and `por_cfg_smp_o` stays 0.
- R3: A low sensed soft pin or a `tap_srst_i` pulse starts a soft sequence when the block is idle. In a soft sequence, `soft_drv_o` is high for exactly SOFT_CYCLES cycles, `hard_drv_o` stays 0, and neither sample strobe pulses.
- R4: Once the drives drop, `core_rst_o` stays 1 while either pin reads low. It falls on the third rising edge after both pins read high.
- R5: An expiry pulse whose enable is low has no effect: `core_rst_o` stays 0 and `stat_o` is unchanged.
- R6: An external soft-pin assertion or a test-port strobe is ignored while any sequence runs. The running sequence keeps its length and its status bit is not set.
- R7: A hard request during a soft sequence restarts at the hard level. `hard_drv_o` rises and stays high for a full HARD_CYCLES cycles.
- R8: `stat_o` bit positions are: 0 power-on, 1 external hard pin, 2 external soft pin, 3 watchdog, 4 bus monitor, 5 test-port command. Every accepted source of the winning level sets its bit when its sequence starts. Set bits stay set, so several bits can be 1.
- R9: When `stat_wr_i` is high, each bit of `stat_o` whose `stat_wdata_i` bit is 1 clears after the edge. Bits written with 0 keep their value.
- R10: Every pin and request input passes through a two-flop synchronizer. A request driven just after one rising edge shows at the drive outputs after the third rising edge that follows, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| hard_pin_i | input | 1 | Sensed level of the open-drain hard reset pin (low = asserted) |
| soft_pin_i | input | 1 | Sensed level of the open-drain soft reset pin (low = asserted) |
| wdog_exp_i | input | 1 | Watchdog expiry pulse |
| wdog_en_i | input | 1 | Watchdog reset enable |
| bmon_exp_i | input | 1 | Bus monitor expiry pulse |
| bmon_en_i | input | 1 | Bus monitor reset enable |
| tap_srst_i | input | 1 | Soft reset command strobe from the test port |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 6 | Status write data, ones clear bits |
| core_rst_o | output | 1 | Core reset, active high |
| hard_drv_o | output | 1 | Pull-low enable for the hard reset pin |
| soft_drv_o | output | 1 | Pull-low enable for the soft reset pin |
| por_cfg_smp_o | output | 1 | One-cycle strobe to capture power-on settings |
| hrcw_smp_o | output | 1 | One-cycle strobe to capture the hard reset settings word |
| stat_o | output | 6 | Reset source status |

## Verification
A wrong level register shows right away as the wrong pair of drive enables, or as a sample strobe on the wrong sequence, at the end of the drive window. A broken cycle counter shows as a drive window of the wrong length, which the bench measures to the cycle. A lost wait state shows as the core reset dropping while a pin is still held low. A bad source mask or priority choice shows as a status bit set or missing right after the sequence ends, or as a deeper request failing to raise the hard drive within three cycles.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        LVL_SOFT = 2'd0,
        LVL_HARD = 2'd1,
        LVL_POR  = 2'd2
    } rst_lvl_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_st_e;

    localparam int SRC_N     = 6;
    localparam int SRC_POR   = 0;
    localparam int SRC_XHARD = 1;
    localparam int SRC_XSOFT = 2;
    localparam int SRC_WDOG  = 3;
    localparam int SRC_BMON  = 4;
    localparam int SRC_TAP   = 5;

    localparam logic [SRC_N-1:0] HARD_SRC_MASK = 6'b011010;
    localparam logic [SRC_N-1:0] SOFT_SRC_MASK = 6'b100100;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int                WIDTH   = 1,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rst_req_arb.sv
module rst_req_arb
    import rst_seq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hard_pin_s_i,
    input  logic             soft_pin_s_i,
    input  logic             wdog_s_i,
    input  logic             wdog_en_s_i,
    input  logic             bmon_s_i,
    input  logic             bmon_en_s_i,
    input  logic             tap_s_i,
    input  logic             busy_i,
    input  rst_lvl_e         cur_lvl_i,
    output logic             req_vld_o,
    output rst_lvl_e         req_lvl_o,
    output logic [SRC_N-1:0] src_set_o
);

    logic             hard_ok, soft_ok;
    logic [SRC_N-1:0] src_hit;

    always_comb begin
        // a deeper level may interrupt a soft sequence; soft only when idle
        hard_ok = !busy_i || (cur_lvl_i == LVL_SOFT);
        soft_ok = !busy_i;

        src_hit            = '0;
        src_hit[SRC_XHARD] = !hard_pin_s_i && hard_ok;
        src_hit[SRC_WDOG]  = wdog_s_i && wdog_en_s_i && hard_ok;
        src_hit[SRC_BMON]  = bmon_s_i && bmon_en_s_i && hard_ok;
        src_hit[SRC_XSOFT] = !soft_pin_s_i && soft_ok;
        src_hit[SRC_TAP]   = tap_s_i && soft_ok;

        req_vld_o = 1'b0;
        req_lvl_o = LVL_SOFT;
        src_set_o = '0;
        if (|(src_hit & HARD_SRC_MASK)) begin
            req_vld_o = 1'b1;
            req_lvl_o = LVL_HARD;
            src_set_o = src_hit & HARD_SRC_MASK;
        end else if (|(src_hit & SOFT_SRC_MASK)) begin
            req_vld_o = 1'b1;
            req_lvl_o = LVL_SOFT;
            src_set_o = src_hit & SOFT_SRC_MASK;
        end
    end

    // R6
    soft_masked_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |-> ((src_set_o & SOFT_SRC_MASK) == '0));

    // R5
    disabled_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wdog_en_s_i && !bmon_en_s_i && hard_pin_s_i && soft_pin_s_i && !tap_s_i)
        |-> !req_vld_o);

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int HARD_CYCLES = 512,
    parameter int SOFT_CYCLES = 256
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     req_vld_i,
    input  rst_lvl_e req_lvl_i,
    input  logic     hard_pin_s_i,
    input  logic     soft_pin_s_i,
    output logic     busy_o,
    output rst_lvl_e cur_lvl_o,
    output logic     core_rst_o,
    output logic     hard_drv_o,
    output logic     soft_drv_o,
    output logic     por_smp_o,
    output logic     hrcw_smp_o
);

    localparam int MAX_CYC = (HARD_CYCLES > SOFT_CYCLES) ? HARD_CYCLES : SOFT_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC);
    localparam logic [CNT_W-1:0] HARD_LAST = CNT_W'(HARD_CYCLES - 1);
    localparam logic [CNT_W-1:0] SOFT_LAST = CNT_W'(SOFT_CYCLES - 1);

    typedef struct packed {
        seq_st_e          st;
        rst_lvl_e         lvl;
        logic [CNT_W-1:0] cnt;
        logic             core_rst;
        logic             hdrv;
        logic             sdrv;
        logic             psmp;
        logic             hsmp;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        st: ST_DRIVE, lvl: LVL_POR, cnt: '0,
        core_rst: 1'b1, hdrv: 1'b1, sdrv: 1'b1, psmp: 1'b0, hsmp: 1'b0
    };

    fsm_t             fsm_d, fsm_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.psmp = 1'b0;
        fsm_d.hsmp = 1'b0;
        last_cnt   = (fsm_q.lvl == LVL_SOFT) ? SOFT_LAST : HARD_LAST;

        unique case (fsm_q.st)
            ST_DRIVE: begin
                if (fsm_q.cnt == last_cnt) begin
                    fsm_d.st   = ST_WAIT;
                    fsm_d.cnt  = '0;
                    fsm_d.psmp = (fsm_q.lvl == LVL_POR);
                    fsm_d.hsmp = (fsm_q.lvl != LVL_SOFT);
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (hard_pin_s_i && soft_pin_s_i) begin
                    fsm_d.st = ST_IDLE;
                end
            end
            default: ;
        endcase

        // the arbiter only passes requests that outrank the running level
        if (req_vld_i) begin
            fsm_d.st   = ST_DRIVE;
            fsm_d.lvl  = req_lvl_i;
            fsm_d.cnt  = '0;
            fsm_d.psmp = 1'b0;
            fsm_d.hsmp = 1'b0;
        end

        fsm_d.core_rst = (fsm_d.st != ST_IDLE);
        fsm_d.sdrv     = (fsm_d.st == ST_DRIVE);
        fsm_d.hdrv     = (fsm_d.st == ST_DRIVE) && (fsm_d.lvl != LVL_SOFT);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= FSM_RST;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign busy_o     = (fsm_q.st != ST_IDLE);
    assign cur_lvl_o  = fsm_q.lvl;
    assign core_rst_o = fsm_q.core_rst;
    assign hard_drv_o = fsm_q.hdrv;
    assign soft_drv_o = fsm_q.sdrv;
    assign por_smp_o  = fsm_q.psmp;
    assign hrcw_smp_o = fsm_q.hsmp;

    // R1
    por_strobe_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fsm_q.psmp |-> (fsm_q.lvl == LVL_POR && fsm_q.hsmp && fsm_q.st == ST_WAIT));

    // R4
    hold_until_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.st == ST_WAIT && !(hard_pin_s_i && soft_pin_s_i)) |=> fsm_q.core_rst);

    // R7
    hard_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_vld_i && req_lvl_i == LVL_HARD)
        |=> (fsm_q.st == ST_DRIVE && fsm_q.lvl == LVL_HARD && fsm_q.cnt == '0 && fsm_q.hdrv));

    // R2
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.st == ST_DRIVE) |-> (fsm_q.cnt <= last_cnt));

endmodule

// File: rtl/rst_status.sv
module rst_status
    import rst_seq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SRC_N-1:0] set_i,
    input  logic             wr_i,
    input  logic [SRC_N-1:0] wdata_i,
    output logic [SRC_N-1:0] stat_o
);

    localparam logic [SRC_N-1:0] STAT_RST = SRC_N'(1) << SRC_POR;

    logic [SRC_N-1:0] stat_d, stat_q;

    always_comb begin
        // a new event in the same cycle as a clear keeps its bit
        stat_d = (stat_q & ~(wr_i ? wdata_i : '0)) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q <= STAT_RST;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;

    for (genvar k = 0; k < SRC_N; k++) begin : g_bit_chk
        // R8
        bit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[k] |=> stat_q[k]);
        // R9
        bit_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_i && wdata_i[k] && !set_i[k]) |=> !stat_q[k]);
    end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int HARD_CYCLES = 512,
    parameter int SOFT_CYCLES = 256
) (
    input  logic       clk_i,
    input  logic       por_n_i,
    input  logic       hard_pin_i,
    input  logic       soft_pin_i,
    input  logic       wdog_exp_i,
    input  logic       wdog_en_i,
    input  logic       bmon_exp_i,
    input  logic       bmon_en_i,
    input  logic       tap_srst_i,
    input  logic       stat_wr_i,
    input  logic [5:0] stat_wdata_i,
    output logic       core_rst_o,
    output logic       hard_drv_o,
    output logic       soft_drv_o,
    output logic       por_cfg_smp_o,
    output logic       hrcw_smp_o,
    output logic [5:0] stat_o
);

    localparam int SYNC_STAGES = 2;
    localparam int SYNC_W      = 7;
    // pins idle high, strobes idle low
    localparam logic [SYNC_W-1:0] SYNC_RST = 7'b0000011;

    logic [SYNC_W-1:0] raw_in, syn_in;
    logic              busy, req_vld;
    rst_lvl_e          cur_lvl, req_lvl;
    logic [SRC_N-1:0]  src_set;

    assign raw_in = {tap_srst_i, bmon_en_i, bmon_exp_i, wdog_en_i, wdog_exp_i,
                     soft_pin_i, hard_pin_i};

    rst_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (por_n_i),
        .d_i    (raw_in),
        .q_o    (syn_in)
    );

    rst_req_arb u_arb (
        .clk_i        (clk_i),
        .rst_ni       (por_n_i),
        .hard_pin_s_i (syn_in[0]),
        .soft_pin_s_i (syn_in[1]),
        .wdog_s_i     (syn_in[2]),
        .wdog_en_s_i  (syn_in[3]),
        .bmon_s_i     (syn_in[4]),
        .bmon_en_s_i  (syn_in[5]),
        .tap_s_i      (syn_in[6]),
        .busy_i       (busy),
        .cur_lvl_i    (cur_lvl),
        .req_vld_o    (req_vld),
        .req_lvl_o    (req_lvl),
        .src_set_o    (src_set)
    );

    rst_seq_fsm #(
        .HARD_CYCLES (HARD_CYCLES),
        .SOFT_CYCLES (SOFT_CYCLES)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (por_n_i),
        .req_vld_i    (req_vld),
        .req_lvl_i    (req_lvl),
        .hard_pin_s_i (syn_in[0]),
        .soft_pin_s_i (syn_in[1]),
        .busy_o       (busy),
        .cur_lvl_o    (cur_lvl),
        .core_rst_o   (core_rst_o),
        .hard_drv_o   (hard_drv_o),
        .soft_drv_o   (soft_drv_o),
        .por_smp_o    (por_cfg_smp_o),
        .hrcw_smp_o   (hrcw_smp_o)
    );

    rst_status u_stat (
        .clk_i   (clk_i),
        .rst_ni  (por_n_i),
        .set_i   (src_set),
        .wr_i    (stat_wr_i),
        .wdata_i (stat_wdata_i),
        .stat_o  (stat_o)
    );

endmodule

// File: tb/rst_seq_ctrl_test.sv
module rst_seq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int HC = 16;
    localparam int SC = 8;

    logic       clk = 1'b0;
    logic       por_n, wdog_exp, wdog_en, bmon_exp, bmon_en, tap;
    logic       ext_hard, ext_soft, stat_wr;
    logic [5:0] stat_wdata;
    logic       hard_pin, soft_pin;
    logic       core_rst, hard_drv, soft_drv, psmp, hsmp;
    logic [5:0] stat;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int hn, sn, pn, hw;

    always #(CLK_PERIOD/2) clk = ~clk;

    // open-drain pins: low when anyone pulls
    assign hard_pin = !(hard_drv | ext_hard);
    assign soft_pin = !(soft_drv | ext_soft);

    rst_seq_ctrl #(.HARD_CYCLES(HC), .SOFT_CYCLES(SC)) uut (
        .clk_i(clk), .por_n_i(por_n), .hard_pin_i(hard_pin), .soft_pin_i(soft_pin),
        .wdog_exp_i(wdog_exp), .wdog_en_i(wdog_en), .bmon_exp_i(bmon_exp),
        .bmon_en_i(bmon_en), .tap_srst_i(tap), .stat_wr_i(stat_wr),
        .stat_wdata_i(stat_wdata), .core_rst_o(core_rst), .hard_drv_o(hard_drv),
        .soft_drv_o(soft_drv), .por_cfg_smp_o(psmp), .hrcw_smp_o(hsmp), .stat_o(stat)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic bit is_hard(input int src);
        return (src == 1 || src == 3 || src == 4);
    endfunction

    function automatic int exp_hlen(input int src);
        return is_hard(src) ? HC : 0;
    endfunction

    function automatic int exp_slen(input int src);
        return is_hard(src) ? HC : SC;
    endfunction

    // measure one sequence: drive lengths, then strobes until core reset drops
    task automatic run_seq(output int h, output int s, output int p, output int w);
        int guard = 0;
        h = 0; s = 0; p = 0; w = 0;
        while (!soft_drv && guard < 20) begin tick(); guard++; end
        while (soft_drv && s < 4 * HC) begin
            s++;
            if (hard_drv) h++;
            if (psmp) p++;
            if (hsmp) w++;
            tick();
        end
        guard = 0;
        while (core_rst && guard < 100) begin
            if (psmp) p++;
            if (hsmp) w++;
            tick();
            guard++;
        end
    endtask

    task automatic fire(input int src, input bit en);
        case (src)
            1: begin ext_hard = 1'b1; tick(); tick(); ext_hard = 1'b0; end
            2: begin ext_soft = 1'b1; tick(); tick(); ext_soft = 1'b0; end
            3: begin wdog_en = en; wdog_exp = 1'b1; tick(); wdog_exp = 1'b0; end
            4: begin bmon_en = en; bmon_exp = 1'b1; tick(); bmon_exp = 1'b0; end
            default: begin tap = 1'b1; tick(); tap = 1'b0; end
        endcase
    endtask

    task automatic clr_stat(input logic [5:0] mask);
        stat_wr = 1'b1; stat_wdata = mask; tick();
        stat_wr = 1'b0; stat_wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, bad;
        void'($urandom(32'd20245));
        por_n = 1'b0; wdog_exp = 0; wdog_en = 0; bmon_exp = 0; bmon_en = 0; tap = 0;
        ext_hard = 0; ext_soft = 0; stat_wr = 0; stat_wdata = '0;
        repeat (3) tick();

        // R1 reset state
        chk("R1 core_rst in reset", int'(core_rst), 1);
        chk("R1 hard_drv in reset", int'(hard_drv), 1);
        chk("R1 soft_drv in reset", int'(soft_drv), 1);
        chk("R1 stat in reset", int'(stat), 1);
        por_n = 1'b1;
        run_seq(hn, sn, pn, hw);
        chk("R1 por hard drive length", hn, HC);
        chk("R1 por soft drive length", sn, HC);
        chk("R1 por cfg strobe count", pn, 1);
        chk("R1 por hrcw strobe count", hw, 1);
        chk("R1 core_rst released", int'(core_rst), 0);
        tick();

        // R10 latency, R2 watchdog hard sequence
        clr_stat(6'h3F);
        chk("R9 clear all", int'(stat), 0);
        wdog_en = 1'b1; wdog_exp = 1'b1; tick(); wdog_exp = 1'b0;
        chk("R10 no drive after edge 1", int'(hard_drv), 0);
        tick();
        chk("R10 no drive after edge 2", int'(hard_drv), 0);
        tick();
        chk("R10 drive after edge 3", int'(hard_drv), 1);
        run_seq(hn, sn, pn, hw);
        chk("R2 wdog hard length", hn, HC);
        chk("R2 wdog soft length", sn, HC);
        chk("R2 wdog no por strobe", pn, 0);
        chk("R2 wdog hrcw strobe", hw, 1);
        chk("R8 wdog status bit3", int'(stat), 8);
        wdog_en = 1'b0;
        tick();

        // R5 disabled bus monitor
        clr_stat(6'h3F);
        fire(4, 1'b0);
        bad = 0;
        repeat (6) begin tick(); if (core_rst || hard_drv) bad++; end
        chk("R5 disabled expiry no reset", bad, 0);
        chk("R5 disabled expiry status", int'(stat), 0);

        // R3 external soft pin
        fire(2, 1'b0);
        run_seq(hn, sn, pn, hw);
        chk("R3 ext soft length", sn, SC);
        chk("R3 ext soft no hard drive", hn, 0);
        chk("R3 ext soft no strobes", pn + hw, 0);
        chk("R8 ext soft status bit2", int'(stat), 4);
        tick();

        // R6 soft requests ignored during a hard sequence
        clr_stat(6'h3F);
        fork
            run_seq(hn, sn, pn, hw);
            begin
                fire(1, 1'b0);
                n = 0;
                while (!hard_drv && n < 10) begin tick(); n++; end
                repeat (3) tick();
                tap = 1'b1; tick(); tap = 1'b0;
                ext_soft = 1'b1; tick(); tick(); ext_soft = 1'b0;
            end
        join
        chk("R6 hard length unchanged", hn, HC);
        chk("R6 status only ext hard", int'(stat), 2);
        tick();

        // R7 hard request restarts a soft sequence
        clr_stat(6'h3F);
        fork
            run_seq(hn, sn, pn, hw);
            begin
                fire(5, 1'b0);
                n = 0;
                while (!soft_drv && n < 10) begin tick(); n++; end
                repeat (2) tick();
                wdog_en = 1'b1;
                fire(3, 1'b1);
            end
        join
        chk("R7 restarted hard length", hn, HC);
        chk("R7 restarted hrcw strobe", hw, 1);
        chk("R8 tap and wdog bits", int'(stat), 40);
        wdog_en = 1'b0;
        tick();

        // R9 selective clear
        clr_stat(6'b001000);
        chk("R9 clear bit3 only", int'(stat), 32);
        clr_stat(6'b000000);
        chk("R9 zero write keeps bits", int'(stat), 32);
        clr_stat(6'h3F);

        // R4 wait on pin held low externally
        fire(5, 1'b0);
        n = 0;
        while (!soft_drv && n < 10) begin tick(); n++; end
        ext_soft = 1'b1;
        while (soft_drv) tick();
        bad = 0;
        repeat (10) begin tick(); if (!core_rst) bad++; end
        chk("R4 core_rst held while pin low", bad, 0);
        ext_soft = 1'b0;
        n = 0;
        while (core_rst && n < 10) begin tick(); n++; end
        chk("R4 release delay", n, 3);
        chk("R6 held pin not recorded", int'(stat), 32);
        tick();

        // R2 / R3 / R5 / R8 random sources
        for (int it = 0; it < 30; it++) begin
            int src;
            bit en;
            src = int'($urandom_range(5, 1));
            en = 1'($urandom_range(1, 0));
            clr_stat(6'h3F);
            repeat (int'($urandom_range(4, 0))) tick();
            fire(src, en);
            if ((src == 3 || src == 4) && !en) begin
                bad = 0;
                repeat (6) begin tick(); if (core_rst) bad++; end
                chk("R5 random disabled expiry", bad, 0);
                chk("R5 random disabled status", int'(stat), 0);
            end else begin
                run_seq(hn, sn, pn, hw);
                chk("R2 R3 random hard length", hn, exp_hlen(src));
                chk("R2 R3 random soft length", sn, exp_slen(src));
                chk("R2 R3 random hrcw strobe", hw, is_hard(src) ? 1 : 0);
                chk("R1 random no por strobe", pn, 0);
                chk("R8 random status", int'(stat), 1 << src);
            end
            wdog_en = 1'b0; bmon_en = 1'b0;
            tick();
        end

        // R1 power-on during a hard sequence
        fire(1, 1'b0);
        n = 0;
        while (!hard_drv && n < 10) begin tick(); n++; end
        repeat (4) tick();
        por_n = 1'b0;
        tick();
        chk("R1 por mid-sequence status", int'(stat), 1);
        chk("R1 por mid-sequence drive", int'(hard_drv), 1);
        por_n = 1'b1;
        run_seq(hn, sn, pn, hw);
        chk("R1 por restart length", hn, HC);
        chk("R1 por restart cfg strobe", pn, 1);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule